// File: doc/BRIEF.md
# Successive-Approximation Delay-Code Lock Controller

This block is the digital loop controller of a delay-locked loop whose delay line takes an n-bit binary code. From a single early/late decision per clock, it binary-searches the delay code, starting at mid-scale and settling one bit per cycle, most significant bit first. When the least significant bit has been settled, the final code is captured into a hold register. The code multiplexer then feeds the delay line from that register, and the controller reports lock and enters a low-activity sleep state. In that state the search register is frozen and the search-enable output is low.

While asleep the controller keeps watching a phase-error flag. A flag that stays high on two consecutive clock edges wakes the loop. Lock and sleep drop together, the multiplexer returns to the live search code, and a fresh search starts from mid-scale. With the default six-bit code, the next lock arrives six cycles after the wake.

Top module: `dll_sar_lock_ctl`

## Requirements
- R1: With synchronous active-high reset `rst` high at a clock edge, after that edge `dly_code` equals mid-scale (only bit CODE_W-1 set; 32 for the default width), `locked` and `asleep` are 0, and `srch_en` is 1.
- R2: During a search, each clock edge settles one code bit, highest first. After k edges from the search start (k < CODE_W), the top k bits of `dly_code` hold their settled values, bit CODE_W-1-k is 1, and all lower bits are 0.
- R3: The bit under trial is kept at 1 when `dly_more` (1 = the delay must grow) is high at that edge, and is cleared to 0 when it is low.
- R4: `locked` and `asleep` rise after exactly the CODE_W-th search edge. In that same cycle `srch_en` falls, and `dly_code` equals the settled code, which is delivered from the hold register.
- R5: While asleep, `dly_code` stays fixed at the held code whatever `dly_more` does, and `srch_en` stays 0.
- R6: While asleep, a `ph_err` high for only one edge at a time, or not at all, leaves `locked` and `asleep` high and `dly_code` unchanged.
- R7: While asleep, `ph_err` high on two consecutive edges makes `locked` and `asleep` fall after the second edge. In that same cycle `srch_en` rises and `dly_code` returns to mid-scale.
- R8: After a wake, a new lock is reached CODE_W cycles later, with the new settled code.
- R9: During a search, `ph_err` has no effect: the search proceeds and locks as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_more | input | 1 | Phase decision: 1 = delay must increase, 0 = decrease |
| ph_err | input | 1 | Phase-error flag watched while asleep |
| dly_code | output | CODE_W | Code to the delay line (live search or held) |
| locked | output | 1 | Lock reached |
| asleep | output | 1 | Sleep state, search logic gated |
| srch_en | output | 1 | Enable for the search logic |

## Verification
The assertions assume that `rst` is asserted for at least one edge before any other check matters. They also assume that `dly_more` and `ph_err` are stable single-bit values at each rising edge, with no X once reset is released. The bench drives both inputs only at falling edges. It derives `dly_more` combinationally from `dly_code` through a modeled delay line with a chosen target code, so every search converges to that target. It releases `ph_err` after the lock sample point, so the wake filter starts each sleep period from a clean history.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;
  typedef enum logic {ST_SEARCH = 1'b0, ST_SLEEP = 1'b1} loop_st_e;
endpackage

// File: rtl/dll_sar_search.sv
module dll_sar_search #(
  parameter int CODE_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              restart,
  input  logic              more,
  output logic [CODE_W-1:0] trial,
  output logic [CODE_W-1:0] trial_nxt,
  output logic              last_bit
);
  localparam logic [CODE_W-1:0] MID     = CODE_W'(1) << (CODE_W - 1);
  localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(CODE_W - 1);

  logic [IDX_W-1:0] idx;

  // settle the bit under trial, then arm the next lower bit
  function automatic logic [CODE_W-1:0] sar_step(
    input logic [CODE_W-1:0] cur,
    input logic [IDX_W-1:0]  pos,
    input logic              keep
  );
    logic [CODE_W-1:0] r;
    r = cur;
    r[pos] = keep;
    if (pos != '0) r[pos - 1'b1] = 1'b1;
    return r;
  endfunction

  assign trial_nxt = sar_step(trial, idx, more);
  assign last_bit  = (idx == '0);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      trial <= MID;
      idx   <= TOP_IDX;
    end else if (step_en) begin
      trial <= trial_nxt;
      if (idx != '0) idx <= idx - 1'b1;
    end
  end
endmodule

// File: rtl/dll_code_hold.sv
module dll_code_hold #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] load_val,
  input  logic              use_hold,
  input  logic [CODE_W-1:0] live_code,
  output logic [CODE_W-1:0] code_out
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)       held <= MID;
    else if (load) held <= load_val;
  end

  assign code_out = use_hold ? held : live_code;
endmodule

// File: rtl/dll_loop_state.sv
module dll_loop_state
  import dll_lock_pkg::*;
#(
  parameter int WAKE_RUN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic search_done,
  input  logic ph_err,
  output logic in_sleep,
  output logic wake_ev
);
  localparam int RUN_W = (WAKE_RUN > 1) ? $clog2(WAKE_RUN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(WAKE_RUN - 1);

  loop_st_e         st;
  logic [RUN_W-1:0] err_run;

  assign in_sleep = (st == ST_SLEEP);
  assign wake_ev  = in_sleep && ph_err && (err_run == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_SEARCH;
      err_run <= '0;
    end else begin
      case (st)
        ST_SEARCH: begin
          err_run <= '0;
          if (search_done) st <= ST_SLEEP;
        end
        default: begin
          if (wake_ev) begin
            st      <= ST_SEARCH;
            err_run <= '0;
          end else if (ph_err) begin
            err_run <= err_run + 1'b1;
          end else begin
            err_run <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dll_sar_lock_ctl.sv
module dll_sar_lock_ctl #(
  parameter int CODE_W   = 6,
  parameter int WAKE_RUN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dly_more,
  input  logic              ph_err,
  output logic [CODE_W-1:0] dly_code,
  output logic              locked,
  output logic              asleep,
  output logic              srch_en
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  logic [CODE_W-1:0] trial;
  logic [CODE_W-1:0] trial_nxt;
  logic              last_bit;
  logic              in_sleep;
  logic              wake_ev;
  logic              done_ev;

  assign srch_en = !in_sleep;
  assign done_ev = srch_en && last_bit;
  assign locked  = in_sleep;
  assign asleep  = in_sleep;

  dll_sar_search #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_search (
    .clk       (clk),
    .rst       (rst),
    .step_en   (srch_en),
    .restart   (wake_ev),
    .more      (dly_more),
    .trial     (trial),
    .trial_nxt (trial_nxt),
    .last_bit  (last_bit)
  );

  dll_code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (done_ev),
    .load_val  (trial_nxt),
    .use_hold  (in_sleep),
    .live_code (trial),
    .code_out  (dly_code)
  );

  dll_loop_state #(.WAKE_RUN(WAKE_RUN)) u_state (
    .clk         (clk),
    .rst         (rst),
    .search_done (done_ev),
    .ph_err      (ph_err),
    .in_sleep    (in_sleep),
    .wake_ev     (wake_ev)
  );
endmodule

// File: rtl/dll_sar_lock_chk.sv
module dll_sar_lock_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ph_err,
  input logic [CODE_W-1:0] dly_code,
  input logic              locked,
  input logic              asleep,
  input logic              srch_en,
  input logic              done_ev,
  input logic              wake_ev
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam int CNT_W = $clog2(CODE_W + 1) + 1;

  logic [CNT_W-1:0] srch_cnt;

  always_ff @(posedge clk) begin
    if (rst || wake_ev)               srch_cnt <= '0;
    else if (!asleep && srch_cnt < CNT_W'(CODE_W)) srch_cnt <= srch_cnt + 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dly_code == MID) && !locked && !asleep && srch_en);

  a_r4_lock_after_done: assert property (@(posedge clk) disable iff (rst)
    done_ev |=> locked && asleep && !srch_en);

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    asleep && $past(asleep) |-> $stable(dly_code));

  a_r6_no_wake_without_err: assert property (@(posedge clk) disable iff (rst)
    asleep && !ph_err |=> asleep && locked);

  a_r7_wake_restarts: assert property (@(posedge clk) disable iff (rst)
    wake_ev |=> !locked && !asleep && srch_en && (dly_code == MID));

  a_r8_relock_time: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> srch_cnt == CNT_W'(CODE_W));

  a_r9_search_ignores_err: assert property (@(posedge clk) disable iff (rst)
    !asleep && !done_ev |=> !asleep);
endmodule

bind dll_sar_lock_ctl dll_sar_lock_chk #(.CODE_W(CODE_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .ph_err   (ph_err),
  .dly_code (dly_code),
  .locked   (locked),
  .asleep   (asleep),
  .srch_en  (srch_en),
  .done_ev  (done_ev),
  .wake_ev  (wake_ev)
);

// File: tb/test_dll_sar_lock_ctl.sv
module test_dll_sar_lock_ctl;
  localparam int W = 6;
  localparam int MIDV = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ph_err = 1'b0;
  logic         dly_more;
  logic [W-1:0] tgt = '0;
  logic [W-1:0] dly_code;
  logic         locked, asleep, srch_en;

  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;

  // delay-line model: grow the delay while the code does not exceed the target
  assign dly_more = !(dly_code > tgt);

  dll_sar_lock_ctl #(.CODE_W(W), .WAKE_RUN(2)) i_dll_sar_lock_ctl (
    .clk(clk), .rst(rst), .dly_more(dly_more), .ph_err(ph_err),
    .dly_code(dly_code), .locked(locked), .asleep(asleep), .srch_en(srch_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int step_code(input logic [W-1:0] t, input int k);
    int e = 0;
    for (int b = W - 1; b >= 0; b--) begin
      if (b >= W - k)          e += int'(t[b]) << b;
      else if (b == W - 1 - k) e += 1 << b;
    end
    return e;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 code", dly_code, MIDV);
    chk("R1 locked", locked, 0);
    chk("R1 asleep", asleep, 0);
    chk("R1 srch_en", srch_en, 1);
    rst = 1'b0;
  endtask

  task automatic t_search(input logic [W-1:0] t, input logic err_during);
    tgt = t;
    ph_err = err_during;
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (k < W) begin
        chk(err_during ? "R9 R2 step code" : "R2 R3 step code", dly_code, step_code(t, k));
        chk("R4 not yet locked", locked, 0);
      end else begin
        chk("R4 R8 final code", dly_code, int'(t));
        chk("R4 locked", locked, 1);
        chk("R4 asleep", asleep, 1);
        chk("R4 srch_en", srch_en, 0);
      end
    end
    ph_err = 1'b0;
  endtask

  task automatic t_sleep_hold();
    int held = dly_code;
    for (int i = 0; i < 4; i++) begin
      tgt = (i % 2 == 0) ? '0 : '1;
      @(negedge clk);
      chk("R5 held code", dly_code, held);
      chk("R5 srch_en", srch_en, 0);
    end
  endtask

  task automatic t_glitch();
    int held = dly_code;
    for (int i = 0; i < 6; i++) begin
      ph_err = (i % 2 == 0);
      @(negedge clk);
      chk("R6 locked", locked, 1);
      chk("R6 code", dly_code, held);
    end
    ph_err = 1'b0;
    @(negedge clk);
    chk("R6 asleep", asleep, 1);
  endtask

  task automatic t_wake();
    ph_err = 1'b1;
    @(negedge clk);
    chk("R7 still locked after one edge", locked, 1);
    @(negedge clk);
    chk("R7 locked fell", locked, 0);
    chk("R7 asleep fell", asleep, 0);
    chk("R7 srch_en", srch_en, 1);
    chk("R7 mid-scale", dly_code, MIDV);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_search(6'd45, 1'b0);
    t_sleep_hold();
    t_glitch();
    t_wake();
    t_search(6'd0, 1'b1);
    t_sleep_hold();
    t_wake();
    ph_err = 1'b0;
    t_search(6'd63, 1'b0);
    t_glitch();
    t_reset();
    t_search(6'd31, 1'b0);
    t_wake();
    t_search(6'd18, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule